// File: doc/BRIEF.md
# Byte-Wide Asynchronous Serial Port with Selectable Error Interrupt

This block is a register-mapped asynchronous serial port with one transmitter and one receiver. Software programs it over a byte-wide read/write port. A mode register holds a master clock enable, separate transmit and receive enables, a parity mode, the character length (7 or 8 bits) and the stop-bit count (1 or 2). An external baud generator supplies `baud_tick` at sixteen times the bit rate. The prescaler select and divisor registers are stored in the block and driven out to that generator. A receive buffer, a transmit buffer, an error status register and a transmit status register complete the map. The receive interrupt reports new characters. The transmit interrupt reports that the last written character has left the line. A mode bit steers receive errors either onto the receive interrupt or onto a separate error interrupt.

The transmitter is a state machine with the states TX_IDLE, TX_START, TX_DATA, TX_PAR and TX_STOP. TX_IDLE goes to TX_START when the transmit buffer holds a byte, and the shifter takes that byte. TX_START goes to TX_DATA after one bit time. TX_DATA goes to TX_PAR after the last data bit when parity is on, and to TX_STOP when it is off. TX_PAR goes to TX_STOP after one bit time. TX_STOP goes back to TX_IDLE after the last stop bit.

The receiver has the states RX_IDLE, RX_START, RX_DATA, RX_PAR and RX_STOP. RX_IDLE goes to RX_START on a high-to-low line edge seen on a tick. At mid start bit, RX_START goes to RX_DATA if the line is still low, and back to RX_IDLE if it is high. RX_DATA goes to RX_PAR or to RX_STOP after the last data bit. RX_PAR goes to RX_STOP after one bit time. RX_STOP goes to RX_IDLE once it has sampled the first stop bit. Either machine is forced to its idle state while its path is not running.

Top module: `uart_err_route`

## Requirements
- R1: Register offsets (3-bit `addr`): 0 mode, 2 receive buffer, 3 error status, 4 transmit buffer (write only, reads 0), 5 transmit status, 6 prescaler select (4 bits, drives `psel_o`), 7 divisor (8 bits, drives `div_o`). The mode, prescaler and divisor registers read back what was written.
- R2: Mode bits are: 7 clock enable, 6 transmit enable, 5 receive enable, 4:3 parity select, 2 eight-bit characters (0 = seven), 1 two stop bits (0 = one), 0 error routing. A transmitted frame is one low start bit, then data LSB first (bits 6:0 only in 7-bit mode), then an optional parity bit, then one or two high stop bits. Each bit lasts 16 ticks.
- R3: Parity select 00 sends no parity bit, 01 sends a constant 0, 10 makes the count of ones in data plus parity odd, and 11 makes it even. The receiver checks the same rule.
- R4: Transmit status bit 1 is high while a byte waits in the transmit buffer, and bit 0 is high while the shifter is busy. `irq_tx` pulses for one cycle when the last stop bit ends and no further byte is waiting.
- R5: The receiver samples each bit at mid-bit. It writes a completed character to the receive buffer with bit 7 forced to 0 in 7-bit mode. Reading offset 2 marks the buffer as read.
- R6: Error status bit 2 is parity error, bit 1 is framing error (first stop bit sampled low), and bit 0 is overrun. Reading offset 3 clears all three bits.
- R7: A character that completes while the previous one is unread sets the overrun bit and replaces the buffered character.
- R8: With mode bit 0 set, every completed character pulses `irq_rx`, including one with an error. With mode bit 0 clear, a character with an error pulses `irq_err` and not `irq_rx`, and a clean character pulses `irq_rx`.
- R9: While the clock enable is 0, both shifters are idle, the buffers and all status flags are cleared, transmit buffer writes are ignored, the line stays high, and the transmit and receive enables have no effect.
- R10: After any write to the mode register, neither path runs until 2 baud ticks have passed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_tick | input | 1 | One-cycle pulse at 16x the bit rate |
| addr | input | 3 | Register offset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (clears read-sensitive state) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |
| irq_rx | output | 1 | Receive interrupt pulse |
| irq_tx | output | 1 | Transmit-complete interrupt pulse |
| irq_err | output | 1 | Receive-error interrupt pulse |
| psel_o | output | 4 | Prescaler select to the baud generator |
| div_o | output | 8 | Divisor to the baud generator |

## Verification
The hardest state to reach from the ports is an overrun that arrives together with a framing or parity fault, because the bench must time whole frames against unread buffer state. The bench drives `rxd` with frames it builds itself and can corrupt the parity or stop bit on request. It sends two frames back to back without reading, and it changes the error routing bit between frames. The transmit side is checked by decoding `txd` at mid-bit against frames built from randomly chosen data and modes. A mode write followed at once by a buffer write exercises the settle window.

// File: rtl/uart_er_pkg.sv
package uart_er_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        PAR_NONE = 2'b00,
        PAR_ZERO = 2'b01,
        PAR_ODD  = 2'b10,
        PAR_EVEN = 2'b11
    } par_e;

    typedef enum logic [2:0] {
        TX_IDLE, TX_START, TX_DATA, TX_PAR, TX_STOP
    } tx_state_e;

    typedef enum logic [2:0] {
        RX_IDLE, RX_START, RX_DATA, RX_PAR, RX_STOP
    } rx_state_e;

    localparam logic [2:0] A_MODE = 3'd0;
    localparam logic [2:0] A_RXB  = 3'd2;
    localparam logic [2:0] A_ERR  = 3'd3;
    localparam logic [2:0] A_TXB  = 3'd4;
    localparam logic [2:0] A_TXS  = 3'd5;
    localparam logic [2:0] A_PSEL = 3'd6;
    localparam logic [2:0] A_DIV  = 3'd7;

    localparam int M_CAE = 7;
    localparam int M_TXE = 6;
    localparam int M_RXE = 5;
    localparam int M_PS_HI = 4;
    localparam int M_PS_LO = 3;
    localparam int M_LEN8 = 2;
    localparam int M_STOP2 = 1;
    localparam int M_ROUTE = 0;

    // Parity bit for already-masked data.
    function automatic logic par_calc(input logic [BYTE_W-1:0] d, input par_e ps);
        logic r;
        unique case (ps)
            PAR_ODD:  r = ~^d;
            PAR_EVEN: r = ^d;
            default:  r = 1'b0;
        endcase
        return r;
    endfunction
endpackage

// File: rtl/uart_er_tx.sv
module uart_er_tx
    import uart_er_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              tick,
    input  logic              len8,
    input  logic              two_stop,
    input  par_e              ps,
    input  logic              load_valid,
    input  logic [BYTE_W-1:0] load_data,
    output logic              take,
    output logic              busy,
    output logic              done,
    output logic              txd
);
    localparam int CNT_W = $clog2(OVS);
    localparam int BIT_W = $clog2(BYTE_W);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(OVS - 1);

    tx_state_e         state, nxt;
    logic [CNT_W-1:0]  cnt;
    logic [BIT_W-1:0]  bitn;
    logic [BYTE_W-1:0] sh;
    logic              pbit;
    logic              stop_n;
    logic              bit_end;
    logic              last_bit;
    logic [BYTE_W-1:0] masked;

    assign bit_end  = tick && (cnt == CNT_LAST);
    assign last_bit = (bitn == (len8 ? BIT_W'(BYTE_W - 1) : BIT_W'(BYTE_W - 2)));
    assign masked   = len8 ? load_data : {1'b0, load_data[BYTE_W-2:0]};

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      state <= TX_IDLE;
        else if (!run)   state <= TX_IDLE;
        else             state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            TX_IDLE:  if (load_valid) nxt = TX_START;
            TX_START: if (bit_end) nxt = TX_DATA;
            TX_DATA:  if (bit_end && last_bit) nxt = (ps == PAR_NONE) ? TX_STOP : TX_PAR;
            TX_PAR:   if (bit_end) nxt = TX_STOP;
            TX_STOP:  if (bit_end && (!two_stop || stop_n)) nxt = TX_IDLE;
            default:  nxt = TX_IDLE;
        endcase
    end

    // Datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0; bitn <= '0; sh <= '0; pbit <= 1'b0; stop_n <= 1'b0;
        end else if (!run) begin
            cnt <= '0; bitn <= '0; sh <= '0; pbit <= 1'b0; stop_n <= 1'b0;
        end else begin
            if (state == TX_IDLE)  cnt <= '0;
            else if (tick)         cnt <= (cnt == CNT_LAST) ? '0 : cnt + 1'b1;
            if (take) begin
                sh     <= masked;
                pbit   <= par_calc(masked, ps);
                bitn   <= '0;
                stop_n <= 1'b0;
            end else if (bit_end) begin
                if (state == TX_DATA) begin
                    sh   <= sh >> 1;
                    bitn <= bitn + 1'b1;
                end
                if (state == TX_STOP) stop_n <= 1'b1;
            end
        end
    end

    // Outputs
    always_comb begin
        take = run && (state == TX_IDLE) && load_valid;
        busy = (state != TX_IDLE);
        done = (state == TX_STOP) && bit_end && (!two_stop || stop_n);
        unique case (state)
            TX_START: txd = 1'b0;
            TX_DATA:  txd = sh[0];
            TX_PAR:   txd = pbit;
            default:  txd = 1'b1;
        endcase
    end

    p_take_starts_r4: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (state == TX_START));
    p_done_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (state == TX_IDLE));
endmodule

// File: rtl/uart_er_rx.sv
module uart_er_rx
    import uart_er_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              tick,
    input  logic              rxd,
    input  logic              len8,
    input  par_e              ps,
    output logic              done,
    output logic [BYTE_W-1:0] data,
    output logic              perr,
    output logic              ferr
);
    localparam int CNT_W = $clog2(OVS);
    localparam int BIT_W = $clog2(BYTE_W);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(OVS - 1);
    localparam logic [CNT_W-1:0] CNT_HALF = CNT_W'(OVS / 2 - 1);

    rx_state_e         state, nxt;
    logic [CNT_W-1:0]  cnt;
    logic [BIT_W-1:0]  bitn;
    logic [BYTE_W-1:0] sh;
    logic              pbit;
    logic              last;
    logic              bit_end;
    logic              mid_hit;
    logic              last_bit;

    assign bit_end  = tick && (cnt == CNT_LAST);
    assign mid_hit  = (state == RX_START) && tick && (cnt == CNT_HALF);
    assign last_bit = (bitn == (len8 ? BIT_W'(BYTE_W - 1) : BIT_W'(BYTE_W - 2)));

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      state <= RX_IDLE;
        else if (!run)   state <= RX_IDLE;
        else             state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            RX_IDLE:  if (tick && last && !rxd) nxt = RX_START;
            RX_START: if (mid_hit) nxt = rxd ? RX_IDLE : RX_DATA;
            RX_DATA:  if (bit_end && last_bit) nxt = (ps == PAR_NONE) ? RX_STOP : RX_PAR;
            RX_PAR:   if (bit_end) nxt = RX_STOP;
            RX_STOP:  if (bit_end) nxt = RX_IDLE;
            default:  nxt = RX_IDLE;
        endcase
    end

    // Datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0; bitn <= '0; sh <= '0; pbit <= 1'b0; last <= 1'b1;
        end else if (!run) begin
            cnt <= '0; bitn <= '0; sh <= '0; pbit <= 1'b0; last <= 1'b1;
        end else begin
            if (tick) last <= rxd;
            if (state == RX_IDLE) cnt <= '0;
            else if (tick)        cnt <= (mid_hit || bit_end) ? '0 : cnt + 1'b1;
            if (mid_hit) bitn <= '0;
            if ((state == RX_DATA) && bit_end) begin
                sh   <= {rxd, sh[BYTE_W-1:1]};
                bitn <= bitn + 1'b1;
            end
            if ((state == RX_PAR) && bit_end) pbit <= rxd;
        end
    end

    // Outputs
    always_comb begin
        data = len8 ? sh : {1'b0, sh[BYTE_W-1:1]};
        done = (state == RX_STOP) && bit_end;
        ferr = done && !rxd;
        perr = done && (ps != PAR_NONE) && (pbit != par_calc(data, ps));
    end

    p_done_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (state == RX_IDLE));
    p_start_on_edge_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == RX_IDLE) && (nxt == RX_START) && run) |-> !rxd);
endmodule

// File: rtl/uart_err_route.sv
module uart_err_route
    import uart_er_pkg::*;
#(
    parameter int OVS          = 16,
    parameter int SETTLE_TICKS = 2,
    parameter int PSEL_W       = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        baud_tick,
    input  logic [2:0]  addr,
    input  logic        wr_en,
    input  logic        rd_en,
    input  logic [7:0]  wdata,
    output logic [7:0]  rdata,
    input  logic        rxd,
    output logic        txd,
    output logic        irq_rx,
    output logic        irq_tx,
    output logic        irq_err,
    output logic [PSEL_W-1:0] psel_o,
    output logic [7:0]  div_o
);
    localparam int SET_W = $clog2(SETTLE_TICKS + 1);

    logic [BYTE_W-1:0] mode, txb, rxb;
    logic [PSEL_W-1:0] psel;
    logic [7:0]        div;
    logic [SET_W-1:0]  settle;
    logic              txb_full, rxb_full;
    logic              pe, fe, ove;
    logic              rx_s1, rx_s2;
    logic              irq_rx_q, irq_tx_q, irq_err_q;

    logic cae, tx_run, rx_run, len8, two_stop, route;
    par_e ps;
    logic tx_take, tx_busy, tx_done;
    logic rx_done, rx_perr, rx_ferr, rx_bad;
    logic [BYTE_W-1:0] rx_data;
    logic wr_mode, wr_txb, rd_rxb, rd_err;

    assign cae      = mode[M_CAE];
    assign len8     = mode[M_LEN8];
    assign two_stop = mode[M_STOP2];
    assign route    = mode[M_ROUTE];
    assign ps       = par_e'(mode[M_PS_HI:M_PS_LO]);
    assign tx_run   = cae && mode[M_TXE] && (settle == '0);
    assign rx_run   = cae && mode[M_RXE] && (settle == '0);
    assign wr_mode  = wr_en && (addr == A_MODE);
    assign wr_txb   = wr_en && (addr == A_TXB);
    assign rd_rxb   = rd_en && (addr == A_RXB);
    assign rd_err   = rd_en && (addr == A_ERR);
    assign rx_bad   = rx_perr || rx_ferr || rxb_full;

    uart_er_tx #(.OVS(OVS)) u_tx (
        .clk(clk), .rst_n(rst_n), .run(tx_run), .tick(baud_tick),
        .len8(len8), .two_stop(two_stop), .ps(ps),
        .load_valid(txb_full), .load_data(txb),
        .take(tx_take), .busy(tx_busy), .done(tx_done), .txd(txd)
    );

    uart_er_rx #(.OVS(OVS)) u_rx (
        .clk(clk), .rst_n(rst_n), .run(rx_run), .tick(baud_tick),
        .rxd(rx_s2), .len8(len8), .ps(ps),
        .done(rx_done), .data(rx_data), .perr(rx_perr), .ferr(rx_ferr)
    );

    // Line synchronizer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_s1 <= 1'b1; rx_s2 <= 1'b1;
        end else begin
            rx_s1 <= rxd; rx_s2 <= rx_s1;
        end
    end

    // Configuration and settle window
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode <= '0; psel <= '0; div <= '0; settle <= '0;
        end else begin
            if (wr_mode) begin
                mode   <= wdata;
                settle <= SET_W'(SETTLE_TICKS);
            end else if (baud_tick && (settle != '0)) begin
                settle <= settle - 1'b1;
            end
            if (wr_en && (addr == A_PSEL)) psel <= wdata[PSEL_W-1:0];
            if (wr_en && (addr == A_DIV))  div  <= wdata;
        end
    end

    // Buffers and status
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            txb <= '0; txb_full <= 1'b0; rxb <= '0; rxb_full <= 1'b0;
            pe <= 1'b0; fe <= 1'b0; ove <= 1'b0;
        end else if (!cae) begin
            txb_full <= 1'b0; rxb <= '0; rxb_full <= 1'b0;
            pe <= 1'b0; fe <= 1'b0; ove <= 1'b0;
        end else begin
            if (wr_txb) begin
                txb <= wdata; txb_full <= 1'b1;
            end else if (tx_take) begin
                txb_full <= 1'b0;
            end
            if (rx_done) begin
                rxb <= rx_data; rxb_full <= 1'b1;
            end else if (rd_rxb) begin
                rxb_full <= 1'b0;
            end
            pe  <= (pe  && !rd_err) || (rx_done && rx_perr);
            fe  <= (fe  && !rd_err) || (rx_done && rx_ferr);
            ove <= (ove && !rd_err) || (rx_done && rxb_full);
        end
    end

    // Interrupt pulses
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_rx_q <= 1'b0; irq_tx_q <= 1'b0; irq_err_q <= 1'b0;
        end else begin
            irq_rx_q  <= rx_done && (route || !rx_bad);
            irq_err_q <= rx_done && !route && rx_bad;
            irq_tx_q  <= tx_done && !txb_full;
        end
    end

    assign irq_rx  = irq_rx_q;
    assign irq_tx  = irq_tx_q;
    assign irq_err = irq_err_q;
    assign psel_o  = psel;
    assign div_o   = div;

    always_comb begin
        unique case (addr)
            A_MODE:  rdata = mode;
            A_RXB:   rdata = rxb;
            A_ERR:   rdata = {5'b0, pe, fe, ove};
            A_TXS:   rdata = {6'b0, txb_full, tx_busy};
            A_PSEL:  rdata = 8'(psel);
            A_DIV:   rdata = div;
            default: rdata = 8'h00;
        endcase
    end

    p_disable_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !cae |=> (!txb_full && !rxb_full && !pe && !fe && !ove));
    p_settle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (settle != '0) |=> txd);
    p_route_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_err |-> !irq_rx);
    p_ove_needs_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ove) |-> $past(rxb_full));
endmodule

// File: tb/tb_uart_err_route.sv
`timescale 1ns/1ps
module tb_uart_err_route;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick;
    logic [2:0] addr = 3'd0;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       rxd = 1'b1;
    logic       txd, irq_rx, irq_tx, irq_err;
    logic [3:0] psel_o;
    logic [7:0] div_o;

    int checks = 0, fails = 0;
    int n_rx = 0, n_tx = 0, n_er = 0;
    int r0, t0, e0, n, bad;
    logic [7:0]  v, d;
    logic [11:0] expb, gotb;
    bit l8, two;
    logic [1:0] ps;

    uart_err_route dut (
        .clk(clk), .rst_n(rst_n), .baud_tick(tick), .addr(addr), .wr_en(wr_en),
        .rd_en(rd_en), .wdata(wdata), .rdata(rdata), .rxd(rxd), .txd(txd),
        .irq_rx(irq_rx), .irq_tx(irq_tx), .irq_err(irq_err),
        .psel_o(psel_o), .div_o(div_o)
    );

    always #4 clk = ~clk;

    always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) tick <= 1'b0; else tick <= ~tick;

    always @(posedge clk) begin
        if (irq_rx)  n_rx++;
        if (irq_tx)  n_tx++;
        if (irq_err) n_er++;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] x);
        @(negedge clk); addr = a; wdata = x; wr_en = 1'b1;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] x);
        @(negedge clk); addr = a; rd_en = 1'b1; #1 x = rdata;
        @(negedge clk); rd_en = 1'b0;
    endtask

    function automatic logic fpar(input logic [7:0] x, input bit e8, input logic [1:0] p);
        logic [7:0] m;
        m = e8 ? x : {1'b0, x[6:0]};
        case (p)
            2'b10:   return ~^m;
            2'b11:   return ^m;
            default: return 1'b0;
        endcase
    endfunction

    function automatic int build(input logic [7:0] x, input bit e8, input logic [1:0] p,
                                 input bit s2, output logic [11:0] b);
        int k;
        b = '1;
        b[0] = 1'b0;
        k = 1;
        for (int i = 0; i < (e8 ? 8 : 7); i++) begin b[k] = x[i]; k++; end
        if (p != 2'b00) begin b[k] = fpar(x, e8, p); k++; end
        b[k] = 1'b1; k++;
        if (s2) k++;
        return k;
    endfunction

    function automatic logic [7:0] mbyte(input logic [1:0] p, input bit e8, input bit s2, input bit rt);
        return 8'hE0 | (8'(p) << 3) | (8'(e8) << 2) | (8'(s2) << 1) | 8'(rt);
    endfunction

    task automatic cap(input int k, output logic [11:0] g);
        int w;
        w = 0;
        g = '1;
        while (txd !== 1'b0 && w < 3000) begin @(negedge clk); w++; end
        repeat (16) @(negedge clk);
        g[0] = txd;
        for (int i = 1; i < k; i++) begin
            repeat (32) @(negedge clk);
            g[i] = txd;
        end
    endtask

    task automatic send(input logic [7:0] x, input bit e8, input logic [1:0] p,
                        input bit badpar, input bit badstop);
        logic [11:0] b;
        int k, pi;
        k = build(x, e8, p, 1'b0, b);
        pi = e8 ? 9 : 8;
        if (badpar) b[pi] = ~b[pi];
        if (badstop) b[k-1] = 1'b0;
        for (int i = 0; i < k; i++) begin
            @(negedge clk); rxd = b[i];
            repeat (31) @(negedge clk);
        end
        @(negedge clk); rxd = 1'b1;
        repeat (8) @(negedge clk);
    endtask

    task automatic cmp_frame(input int k, input logic [11:0] e, input logic [11:0] g);
        int m;
        m = 0;
        for (int i = 0; i < k; i++) if (e[i] !== g[i]) m++;
        chk(m == 0, "R2 R3 tx frame", int'(g), int'(e));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240601));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // Reset state
        rd(3'd0, v); chk(v == 8'h00, "R1 R9 mode after reset", v, 0);
        chk(txd == 1'b1, "R9 line idle after reset", txd, 1);
        rd(3'd5, v); chk(v == 8'h00, "R4 tx status after reset", v, 0);
        rd(3'd3, v); chk(v == 8'h00, "R6 err status after reset", v, 0);
        chk({irq_rx, irq_tx, irq_err} == 3'b000, "R8 irqs after reset", {irq_rx, irq_tx, irq_err}, 0);

        // R1 register map readback
        wr(3'd0, 8'hE5); rd(3'd0, v); chk(v == 8'hE5, "R1 mode readback", v, 8'hE5);
        wr(3'd6, 8'h0B); wr(3'd7, 8'h40);
        chk(psel_o == 4'hB, "R1 prescaler output", psel_o, 4'hB);
        chk(div_o == 8'h40, "R1 divisor output", div_o, 8'h40);
        rd(3'd6, v); chk(v == 8'h0B, "R1 prescaler readback", v, 8'h0B);
        rd(3'd7, v); chk(v == 8'h40, "R1 divisor readback", v, 8'h40);
        rd(3'd4, v); chk(v == 8'h00, "R1 tx buffer reads zero", v, 0);

        // Random transmit frames, every parity mode (R2 R3 R4)
        for (int it = 0; it < 8; it++) begin
            ps = 2'(it % 4); l8 = 1'($urandom()); two = 1'($urandom()); d = 8'($urandom());
            wr(3'd0, mbyte(ps, l8, two, 1'b1));
            repeat (8) @(negedge clk);
            t0 = n_tx;
            n = build(d, l8, ps, two, expb);
            fork
                cap(n, gotb);
                begin wr(3'd4, d); rd(3'd5, v); chk(v[1:0] != 2'b00, "R4 status busy after write", v, 1); end
            join
            cmp_frame(n, expb, gotb);
            repeat (40) @(negedge clk);
            chk(n_tx == t0 + 1, "R4 one irq_tx per frame", n_tx - t0, 1);
            rd(3'd5, v); chk(v == 8'h00, "R4 status idle after frame", v, 0);
        end

        // R10 settle window: buffer written right after a mode write
        wr(3'd0, mbyte(2'b11, 1'b1, 1'b0, 1'b1));
        wr(3'd4, 8'hA6);
        @(negedge clk);
        chk(txd == 1'b1, "R10 no start during settle", txd, 1);
        n = build(8'hA6, 1'b1, 2'b11, 1'b0, expb);
        cap(n, gotb);
        cmp_frame(n, expb, gotb);
        repeat (40) @(negedge clk);

        // Random clean receive, every parity mode (R5 R3 R8)
        for (int it = 0; it < 6; it++) begin
            ps = 2'(it % 4); l8 = 1'($urandom()); d = 8'($urandom());
            wr(3'd0, mbyte(ps, l8, 1'b0, 1'($urandom())));
            repeat (8) @(negedge clk);
            rd(3'd2, v); rd(3'd3, v);
            r0 = n_rx; e0 = n_er;
            send(d, l8, ps, 1'b0, 1'b0);
            chk(n_rx == r0 + 1 && n_er == e0, "R5 R8 irq_rx on clean char", n_rx - r0, 1);
            rd(3'd2, v); chk(v == (l8 ? d : {1'b0, d[6:0]}), "R5 rx data", v, l8 ? d : {1'b0, d[6:0]});
            rd(3'd3, v); chk(v == 8'h00, "R3 R6 no error on clean char", v, 0);
        end

        // R5 seven-bit receive forces bit 7 low
        wr(3'd0, mbyte(2'b00, 1'b0, 1'b0, 1'b1)); repeat (8) @(negedge clk);
        send(8'hFF, 1'b0, 2'b00, 1'b0, 1'b0);
        rd(3'd2, v); chk(v == 8'h7F, "R5 7-bit bit7 zero", v, 8'h7F);

        // Parity error routed to irq_rx (R3 R6 R8)
        wr(3'd0, mbyte(2'b11, 1'b1, 1'b0, 1'b1)); repeat (8) @(negedge clk);
        rd(3'd2, v); rd(3'd3, v);
        r0 = n_rx; e0 = n_er;
        send(8'h3C, 1'b1, 2'b11, 1'b1, 1'b0);
        chk(n_rx == r0 + 1, "R8 error routed to irq_rx", n_rx - r0, 1);
        chk(n_er == e0, "R8 no irq_err when routed", n_er - e0, 0);
        rd(3'd3, v); chk(v == 8'h04, "R6 parity error bit2", v, 4);

        // Framing error routed to irq_err (R6 R8)
        wr(3'd0, mbyte(2'b10, 1'b1, 1'b0, 1'b0)); repeat (8) @(negedge clk);
        rd(3'd2, v); rd(3'd3, v);
        r0 = n_rx; e0 = n_er;
        send(8'h81, 1'b1, 2'b10, 1'b0, 1'b1);
        chk(n_er == e0 + 1, "R8 error on irq_err", n_er - e0, 1);
        chk(n_rx == r0, "R8 no irq_rx on error", n_rx - r0, 0);
        rd(3'd3, v); chk(v == 8'h02, "R6 framing error bit1", v, 2);
        rd(3'd3, v); chk(v == 8'h00, "R6 read clears status", v, 0);

        // Overrun (R7)
        wr(3'd0, mbyte(2'b00, 1'b1, 1'b0, 1'b1)); repeat (8) @(negedge clk);
        rd(3'd2, v); rd(3'd3, v);
        send(8'h11, 1'b1, 2'b00, 1'b0, 1'b0);
        send(8'h5A, 1'b1, 2'b00, 1'b0, 1'b0);
        rd(3'd3, v); chk(v == 8'h01, "R7 overrun bit0", v, 1);
        rd(3'd2, v); chk(v == 8'h5A, "R7 newer char kept", v, 8'h5A);

        // Clock enable off (R9)
        wr(3'd4, 8'hF0);
        wr(3'd0, 8'h00);
        @(negedge clk);
        rd(3'd5, v); chk(v == 8'h00, "R9 tx status cleared", v, 0);
        bad = 0;
        for (int i = 0; i < 64; i++) begin @(negedge clk); if (txd !== 1'b1) bad++; end
        chk(bad == 0, "R9 line high when disabled", bad, 0);
        wr(3'd0, 8'h60); repeat (8) @(negedge clk);
        wr(3'd4, 8'h00);
        rd(3'd5, v); chk(v == 8'h00, "R9 tx write ignored without clock enable", v, 0);
        r0 = n_rx;
        fork
            send(8'h55, 1'b1, 2'b00, 1'b0, 1'b0);
            begin
                bad = 0;
                for (int i = 0; i < 300; i++) begin @(negedge clk); if (txd !== 1'b1) bad++; end
            end
        join
        chk(bad == 0, "R9 enables ignored without clock enable", bad, 0);
        chk(n_rx == r0, "R9 no receive without clock enable", n_rx - r0, 0);
        rd(3'd2, v); chk(v == 8'h00, "R9 rx buffer stays clear", v, 0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule